// File: doc/BRIEF.md
# Partial Load Extraction Unit

This block sits behind the address adder of a 32-bit integer pipeline and turns one load into one data-memory read plus one register write. It takes the load's width/sign code (funct3), the already computed effective address and the destination register index. If the code is one of the five legal load codes and the address is naturally aligned for the access size, it issues a word-aligned read over a valid/ready request channel. It then waits for the returned word on a valid/ready response channel, picks out the addressed byte, halfword or word, extends it to 32 bits and presents it with the destination index for writeback.

Only one load is in flight at a time. A `busy` output tells the issue stage to hold its next load until the current one has finished. Unknown codes and misaligned addresses make no memory access. Instead they raise a one-cycle fault flag. Channel rules: the request keeps `mem_req_valid` high and `mem_req_addr` unchanged until `mem_req_ready` is seen high at a clock edge. The unit drives `mem_rsp_ready` high only while waiting for its own response, so the memory may hold `mem_rsp_valid` as long as it needs. The writeback side has no back-pressure.

Top module: `load_lane_unit`

## Requirements
- R1: After reset `busy`, `mem_req_valid`, `mem_rsp_ready`, `wb_valid` and both fault flags are 0. A load is taken when `ld_valid` is high and `busy` is low. A legal, aligned load raises `busy` in the next cycle, and `busy` stays high until the response handshake. A load presented while `busy` is high is ignored.
- R2: A legal, aligned load raises `mem_req_valid` in the cycle after it is taken, with `mem_req_addr` equal to the load address with bits 1:0 cleared. Both stay unchanged until the cycle after `mem_req_ready` is seen high.
- R3: funct3 000 (signed byte) and 100 (unsigned byte) return the byte chosen by address bits 1:0, in little-endian order (lane 0 is data bits 7:0). The byte is sign-extended or zero-extended, as selected by funct3 bit 2 (0 = signed).
- R4: funct3 001 (signed halfword) and 101 (unsigned halfword) return the halfword chosen by address bit 1 (0 = bits 15:0). It is extended according to funct3 bit 2.
- R5: funct3 010 returns the full 32-bit word unchanged.
- R6: funct3 011, 110 and 111 are illegal. Such a load raises `fault_illegal` for exactly the cycle after it is taken, and makes no request and no writeback.
- R7: A legal halfword load with address bit 0 set, or a word load with address bits 1:0 nonzero, raises `fault_misalign` for exactly the cycle after it is taken. It makes no request and no writeback. When a load is both illegal and misaligned, the illegal fault takes precedence.
- R8: `wb_valid` is high for exactly one cycle: the cycle after the response handshake. It comes with `wb_rd` equal to the load's `ld_rd` and `wb_data` equal to the extracted value.
- R9: A load with `ld_rd` = 0 still makes its memory request and response handshake, but `wb_valid` stays low.
- R10: `mem_rsp_ready` is high only between acceptance of the request and the response handshake. At most one request is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | A load is presented |
| ld_funct3 | input | 3 | Width/sign code of the load |
| ld_addr | input | 32 | Effective byte address |
| ld_rd | input | 5 | Destination register index |
| busy | output | 1 | A load is in flight; new loads are not taken |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Word-aligned read address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Unit can take read data |
| mem_rsp_data | input | 32 | Returned memory word |
| wb_valid | output | 1 | Writeback strobe |
| wb_rd | output | 5 | Writeback register index |
| wb_data | output | 32 | Extended load value |
| fault_misalign | output | 1 | Misaligned load pulse |
| fault_illegal | output | 1 | Illegal funct3 pulse |

## Verification
Every cycle, the assertions check the channel rules and the fault and writeback exclusions. The request must stay stable and aligned while stalled. No request may appear while idle or while a fault is shown. `wb_valid` must be a single-cycle pulse that follows a response handshake and never names register 0. Only the bench's scenarios can show that the right lane and extension come out for each code and address. The same holds for telling the two fault kinds apart, for dropping loads presented while `busy` is high, and for varying delays on both channels.

// File: rtl/ldx_pkg.sv
package ldx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } ldx_state_e;

  // funct3[1:0] is taken directly as the access size code
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_NONE = 2'b11
  } ldx_size_e;

  typedef struct packed {
    logic      legal;
    logic      misalign;
    logic      sign_ext;
    ldx_size_e size;
  } ldx_dec_t;
endpackage

// File: rtl/ldx_decode.sv
module ldx_decode
  import ldx_pkg::*;
(
  input  logic [2:0] funct3,
  input  logic [1:0] addr_lo,
  output ldx_dec_t   dec
);
  always_comb begin
    dec.size     = ldx_size_e'(funct3[1:0]);
    dec.sign_ext = ~funct3[2];
    // legal codes: 000 001 010 100 101
    unique case (funct3)
      3'b000, 3'b001, 3'b010, 3'b100, 3'b101: dec.legal = 1'b1;
      default:                                dec.legal = 1'b0;
    endcase
    unique case (dec.size)
      SZ_HALF: dec.misalign = addr_lo[0];
      SZ_WORD: dec.misalign = |addr_lo;
      default: dec.misalign = 1'b0;
    endcase
  end
endmodule

// File: rtl/ldx_extract.sv
module ldx_extract
  import ldx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] word,
  input  logic [1:0]        lane,
  input  ldx_size_e         size,
  input  logic              sign_ext,
  output logic [DATA_W-1:0] value
);
  localparam int NBYTES = DATA_W / 8;
  localparam int NHALF  = DATA_W / 16;

  logic [7:0]  byte_lane [NBYTES];
  logic [15:0] half_lane [NHALF];

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign byte_lane[b] = word[8*b +: 8];
  end
  for (genvar h = 0; h < NHALF; h++) begin : g_half
    assign half_lane[h] = word[16*h +: 16];
  end

  logic [7:0]  sel_b;
  logic [15:0] sel_h;

  always_comb begin
    sel_b = byte_lane[lane];
    sel_h = half_lane[lane[1]];
    unique case (size)
      SZ_BYTE: value = {{(DATA_W-8){sign_ext & sel_b[7]}}, sel_b};
      SZ_HALF: value = {{(DATA_W-16){sign_ext & sel_h[15]}}, sel_h};
      default: value = word;
    endcase
  end
endmodule

// File: rtl/ldx_ctrl.sv
module ldx_ctrl
  import ldx_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int RD_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [RD_W-1:0]   ld_rd,
  input  ldx_dec_t          dec,
  output logic              busy,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  output logic [1:0]        cap_lane,
  output ldx_size_e         cap_size,
  output logic              cap_sign,
  input  logic [DATA_W-1:0] ext_value,
  output logic              wb_valid,
  output logic [RD_W-1:0]   wb_rd,
  output logic [DATA_W-1:0] wb_data,
  output logic              fault_misalign,
  output logic              fault_illegal
);
  ldx_state_e              state;
  logic [ADDR_W-1:0]       cap_addr;
  logic [RD_W-1:0]         cap_rd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state          <= ST_IDLE;
      cap_addr       <= '0;
      cap_rd         <= '0;
      cap_size       <= SZ_WORD;
      cap_sign       <= 1'b0;
      wb_valid       <= 1'b0;
      wb_rd          <= '0;
      wb_data        <= '0;
      fault_misalign <= 1'b0;
      fault_illegal  <= 1'b0;
    end else begin
      wb_valid       <= 1'b0;
      fault_misalign <= 1'b0;
      fault_illegal  <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (ld_valid) begin
            if (!dec.legal) begin
              fault_illegal <= 1'b1;
            end else if (dec.misalign) begin
              fault_misalign <= 1'b1;
            end else begin
              cap_addr <= ld_addr;
              cap_rd   <= ld_rd;
              cap_size <= dec.size;
              cap_sign <= dec.sign_ext;
              state    <= ST_REQ;
            end
          end
        end
        ST_REQ: begin
          if (mem_req_ready) state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            wb_valid <= (cap_rd != '0);
            wb_rd    <= cap_rd;
            wb_data  <= ext_value;
            state    <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy          = (state != ST_IDLE);
  assign mem_req_valid = (state == ST_REQ);
  assign mem_rsp_ready = (state == ST_WAIT);
  assign mem_req_addr  = {cap_addr[ADDR_W-1:2], 2'b00};
  assign cap_lane      = cap_addr[1:0];
endmodule

// File: rtl/load_lane_unit.sv
module load_lane_unit
  import ldx_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int RD_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic [2:0]        ld_funct3,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [RD_W-1:0]   ld_rd,
  output logic              busy,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic              wb_valid,
  output logic [RD_W-1:0]   wb_rd,
  output logic [DATA_W-1:0] wb_data,
  output logic              fault_misalign,
  output logic              fault_illegal
);
  ldx_dec_t          dec;
  logic [1:0]        cap_lane;
  ldx_size_e         cap_size;
  logic              cap_sign;
  logic [DATA_W-1:0] ext_value;

  ldx_decode u_dec (
    .funct3  (ld_funct3),
    .addr_lo (ld_addr[1:0]),
    .dec     (dec)
  );

  ldx_extract #(.DATA_W(DATA_W)) u_ext (
    .word     (mem_rsp_data),
    .lane     (cap_lane),
    .size     (cap_size),
    .sign_ext (cap_sign),
    .value    (ext_value)
  );

  ldx_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RD_W(RD_W)) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .ld_valid       (ld_valid),
    .ld_addr        (ld_addr),
    .ld_rd          (ld_rd),
    .dec            (dec),
    .busy           (busy),
    .mem_req_valid  (mem_req_valid),
    .mem_req_ready  (mem_req_ready),
    .mem_req_addr   (mem_req_addr),
    .mem_rsp_valid  (mem_rsp_valid),
    .mem_rsp_ready  (mem_rsp_ready),
    .cap_lane       (cap_lane),
    .cap_size       (cap_size),
    .cap_sign       (cap_sign),
    .ext_value      (ext_value),
    .wb_valid       (wb_valid),
    .wb_rd          (wb_rd),
    .wb_data        (wb_data),
    .fault_misalign (fault_misalign),
    .fault_illegal  (fault_illegal)
  );
endmodule

// File: rtl/load_lane_unit_chk.sv
module load_lane_unit_chk #(
  parameter int ADDR_W = 32,
  parameter int RD_W   = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_rsp_valid,
  input logic              mem_rsp_ready,
  input logic              wb_valid,
  input logic [RD_W-1:0]   wb_rd,
  input logic              fault_misalign,
  input logic              fault_illegal
);
  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  p_req_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[1:0] == 2'b00));

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req_valid && !mem_rsp_ready));

  p_fault_no_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_misalign || fault_illegal) |-> (!mem_req_valid && !wb_valid));

  p_one_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fault_misalign, fault_illegal}));

  p_wb_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |=> !wb_valid);

  p_wb_after_rsp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> $past(mem_rsp_valid && mem_rsp_ready));

  p_wb_not_x0_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (wb_rd != '0));

  p_single_out_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req_valid && mem_rsp_ready));
endmodule

bind load_lane_unit load_lane_unit_chk #(.ADDR_W(ADDR_W), .RD_W(RD_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .busy           (busy),
  .mem_req_valid  (mem_req_valid),
  .mem_req_ready  (mem_req_ready),
  .mem_req_addr   (mem_req_addr),
  .mem_rsp_valid  (mem_rsp_valid),
  .mem_rsp_ready  (mem_rsp_ready),
  .wb_valid       (wb_valid),
  .wb_rd          (wb_rd),
  .fault_misalign (fault_misalign),
  .fault_illegal  (fault_illegal)
);

// File: tb/load_lane_unit_test.sv
module load_lane_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_valid = 1'b0;
  logic [2:0]  ld_funct3 = 3'b000;
  logic [31:0] ld_addr = '0;
  logic [4:0]  ld_rd = '0;
  logic        busy;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic        mem_rsp_ready;
  logic [31:0] mem_rsp_data = '0;
  logic        wb_valid;
  logic [4:0]  wb_rd;
  logic [31:0] wb_data;
  logic        fault_misalign;
  logic        fault_illegal;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  load_lane_unit uut (.*);

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  function automatic bit is_legal(input logic [2:0] f);
    return (f == 3'b000) || (f == 3'b100) || (f == 3'b001) || (f == 3'b101) || (f == 3'b010);
  endfunction

  function automatic bit is_mis(input logic [2:0] f, input logic [31:0] a);
    if (f[1:0] == 2'b01) return a[0];
    if (f[1:0] == 2'b10) return a[1:0] != 2'b00;
    return 1'b0;
  endfunction

  function automatic logic [31:0] expect_val(input logic [2:0] f, input logic [31:0] a, input logic [31:0] w);
    logic [7:0]  b;
    logic [15:0] h;
    b = w[a[1:0]*8 +: 8];
    h = a[1] ? w[31:16] : w[15:0];
    case (f)
      3'b000:  return {{24{b[7]}}, b};
      3'b100:  return {24'h0, b};
      3'b001:  return {{16{h[15]}}, h};
      3'b101:  return {16'h0, h};
      default: return w;
    endcase
  endfunction

  task automatic do_load(input logic [2:0] f, input logic [31:0] a, input logic [4:0] rd,
                         input logic [31:0] w, input int rdly, input int sdly, input bit poke);
    bit ill, mis;
    ill = !is_legal(f);
    mis = !ill && is_mis(f, a);
    @(negedge clk);
    check(busy == 1'b0, "R1 idle before load", 32'(busy), 32'd0);
    ld_valid = 1'b1; ld_funct3 = f; ld_addr = a; ld_rd = rd;
    @(negedge clk);
    ld_valid = 1'b0;
    if (ill || mis) begin
      check(fault_illegal == ill, "R6 illegal flag", 32'(fault_illegal), 32'(ill));
      check(fault_misalign == mis, "R7 misalign flag", 32'(fault_misalign), 32'(mis));
      check(!mem_req_valid && !busy, "R7 no request on fault", 32'(mem_req_valid), 32'd0);
      @(negedge clk);
      check(!fault_illegal && !fault_misalign, "R6 fault one cycle", 32'({fault_illegal, fault_misalign}), 32'd0);
      check(!wb_valid && !mem_req_valid, "R6 no writeback", 32'(wb_valid), 32'd0);
      return;
    end
    check(mem_req_valid && busy, "R1 R2 request raised", 32'({mem_req_valid, busy}), 32'd3);
    check(mem_req_addr == {a[31:2], 2'b00}, "R2 aligned address", mem_req_addr, {a[31:2], 2'b00});
    repeat (rdly) begin
      @(negedge clk);
      check(mem_req_valid && mem_req_addr == {a[31:2], 2'b00}, "R2 request held", mem_req_addr, {a[31:2], 2'b00});
    end
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    check(!mem_req_valid && mem_rsp_ready, "R10 waiting for response", 32'({mem_req_valid, mem_rsp_ready}), 32'd1);
    if (poke) begin
      ld_valid = 1'b1; ld_funct3 = 3'b110;
    end
    repeat (sdly) begin
      @(negedge clk);
      check(!wb_valid && busy, "R8 no early writeback", 32'(wb_valid), 32'd0);
    end
    mem_rsp_valid = 1'b1; mem_rsp_data = w; ld_valid = 1'b0;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    check(wb_valid == (rd != 0), "R8 R9 writeback strobe", 32'(wb_valid), 32'(rd != 0));
    if (rd != 0) begin
      check(wb_data == expect_val(f, a, w), f[1] ? "R5 word value" : (f[0] ? "R4 half value" : "R3 byte value"),
            wb_data, expect_val(f, a, w));
      check(wb_rd == rd, "R8 rd index", 32'(wb_rd), 32'(rd));
    end
    check(!busy && !mem_rsp_ready, "R10 idle after response", 32'({busy, mem_rsp_ready}), 32'd0);
    check(!fault_illegal, "R1 load during busy ignored", 32'(fault_illegal), 32'd0);
    @(negedge clk);
    check(!wb_valid, "R8 single-cycle strobe", 32'(wb_valid), 32'd0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected under 200000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [2:0] codes [8];
    codes = '{3'b000, 3'b100, 3'b001, 3'b101, 3'b010, 3'b110, 3'b011, 3'b111};
    void'($urandom(32'd7781));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !mem_req_valid && !mem_rsp_ready && !wb_valid && !fault_illegal && !fault_misalign,
          "R1 reset state", 32'({busy, mem_req_valid, mem_rsp_ready, wb_valid}), 32'd0);

    // R3 byte lanes, signed and unsigned
    for (int l = 0; l < 4; l++) begin
      do_load(3'b000, 32'h1000 + l, 5'd3, 32'h80FF7F01, 0, 0, 0);
      do_load(3'b100, 32'h1000 + l, 5'd4, 32'h80FF7F01, 1, 1, 0);
    end
    // R4 halfword lanes
    do_load(3'b001, 32'h2002, 5'd5, 32'h8001_7FFF, 0, 0, 0);
    do_load(3'b001, 32'h2000, 5'd5, 32'h8001_7FFF, 0, 0, 0);
    do_load(3'b101, 32'h2002, 5'd6, 32'h8001_7FFF, 2, 0, 0);
    // R5 word, with stall poke for R1
    do_load(3'b010, 32'h3004, 5'd31, 32'hDEADBEEF, 2, 3, 1);
    // R9 destination x0
    do_load(3'b010, 32'h3008, 5'd0, 32'h12345678, 1, 1, 0);
    // R6 illegal unsigned word, R7 misaligned
    do_load(3'b110, 32'h4000, 5'd7, 32'h0, 0, 0, 0);
    do_load(3'b001, 32'h4001, 5'd7, 32'h0, 0, 0, 0);
    do_load(3'b010, 32'h4002, 5'd7, 32'h0, 0, 0, 0);
    do_load(3'b111, 32'h4003, 5'd7, 32'h0, 0, 0, 0);

    for (int i = 0; i < 300; i++) begin
      do_load(codes[$urandom % 8], $urandom, 5'($urandom), $urandom,
              int'($urandom % 3), int'($urandom % 3), 1'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule